// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Engine

This block moves data on behalf of on-chip peripherals. Each of its four channels holds a source address, a destination address, an item count and a control word, all written through a small configuration port. A channel wants service when it is enabled, its count is non-zero, and either its selected peripheral request line or its software request bit is high. The engine then raises a bus request toward the CPU bus owner. Once the grant arrives, it spends one clock choosing the winning channel and then runs bus cycles for that channel.

A channel moves data in one of two ways. In single-cycle flyby mode the peripheral drives or takes the data directly, and the engine issues only the memory side of the access. In two-cycle indirect mode the engine reads the item into a holding register and then writes it out. Each address can stay fixed, count up or count down after every item. When the count reaches zero, the channel records termination, can raise an interrupt and stops. With the continuous policy the engine keeps the bus for as long as the request stays high. Otherwise it hands the bus back after every item.

Top module: `dma4_engine`

## Requirements
- R1: After reset, `bus_req`, `bus_rd`, `bus_wr`, `ack`, `done` and `irq` are all low and no channel is armed.
- R2: Channel priority is fixed, with channel 0 highest and channel 3 lowest. The winner is chosen in a dedicated clock after the grant is seen. The first bus cycle therefore begins two clocks after the first clock in which `bus_gnt` is high.
- R3: No bus cycle is issued unless both `bus_req` and `bus_gnt` are high, and none is issued in the clock in which `bus_req` rises. `bus_req` falls once the engine has nothing left to do for the current ownership.
- R4: Flyby mode is selected by control bit 1 = 0 and is one bus cycle per item. With control bit 4 = 0, that cycle is a read (`bus_rd`) at the source address. With control bit 4 = 1, it is a write (`bus_wr`) at the destination address. `bus_rd` and `bus_wr` are never high together.
- R5: Indirect mode is selected by control bit 1 = 1. Each item is a read at the source address, followed in the next clock by a write at the destination address that carries the data read.
- R6: `ack` is one-hot with bit n for channel n. It is high only during the bus cycle on the peripheral side: the read cycle when control bit 4 = 0, the write cycle when it is 1.
- R7: After each item, the source address steps according to control bits [6:5] and the destination address according to bits [8:7]. The encoding is 00 hold, 01 add one, 10 subtract one, 11 hold, and each channel's setting is independent of the others.
- R8: The count (register 2) drops by one per item. When it reaches zero, `done[n]` is set and the channel's enable (bit 0) and software request (bit 10) clear. `irq` is high while any `done[n]` whose interrupt enable (bit 3) is set remains high. Writing the control word (register 3) clears `done[n]`.
- R9: With control bit 2 = 1 (continuous), the engine samples the request in the clock after the acknowledged cycle. If it is still high, the next item follows without dropping `bus_req`. With bit 2 = 0, or with the request low at that sample, `bus_req` falls before the next item.
- R10: Control bit 9 selects the request source: 0 takes `req_pri[n]`, 1 takes `req_sec[n]`, and the unselected line has no effect. Control bit 10 acts as a software request.
- R11: A channel with enable bit 0 clear, or with a zero count, raises no bus request whatever its request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 16 | Write data |
| req_pri | input | 4 | Primary peripheral request per channel |
| req_sec | input | 4 | Secondary peripheral request per channel |
| ack | output | 4 | Per-channel acknowledge |
| bus_req | output | 1 | Request for CPU bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wdata | output | 8 | Write data (indirect mode) |
| bus_rdata | input | 8 | Read data |
| done | output | 4 | Per-channel termination status |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state in the controller shows at the ports within one or two clocks. A wrong arbitration result appears as the wrong `ack` bit on the very first bus cycle. A missed or extra state shifts the first strobe away from two clocks after the grant. Corrupted address or count state shows on `bus_addr` at the next item, or as a block that ends one item early or late, which moves the rise of `done`. The bus-ownership pattern, one `bus_req` rise per block versus one per item, exposes a wrong continuous decision as soon as the second item of a block.

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [NCH-1:0]  req_pri,
  input  logic [NCH-1:0]  req_sec,
  output logic [NCH-1:0]  ack,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic [NCH-1:0]  done,
  output logic            irq
);
  localparam int CB     = 11;
  localparam int B_EN   = 0;
  localparam int B_IND  = 1;
  localparam int B_CONT = 2;
  localparam int B_IE   = 3;
  localparam int B_SIDE = 4;
  localparam int B_SS   = 5;
  localparam int B_DS   = 7;
  localparam int B_SEL  = 9;
  localparam int B_SW   = 10;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ARB, S_FLY, S_RD, S_WR, S_CHK} st_t;

  st_t            st;
  logic [CHW-1:0] cur, win;
  logic [AW-1:0]  src [NCH];
  logic [AW-1:0]  dst [NCH];
  logic [CW-1:0]  cnt [NCH];
  logic [CB-1:0]  ctl [NCH];
  logic [DW-1:0]  hold;
  logic [NCH-1:0] pend, ie_v, done_r;
  logic [CB-1:0]  cc;
  logic           side, item_end;

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      2'b01:   stepped = a + AW'(1);
      2'b10:   stepped = a - AW'(1);
      default: stepped = a;
    endcase
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign pend[i] = ctl[i][B_EN] & (|cnt[i]) &
                     ((ctl[i][B_SEL] ? req_sec[i] : req_pri[i]) | ctl[i][B_SW]);
    assign ie_v[i] = ctl[i][B_IE];
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) win = CHW'(i);
  end

  assign cc        = ctl[cur];
  assign side      = cc[B_SIDE];
  assign item_end  = (st == S_FLY) || (st == S_WR);
  assign bus_req   = (st != S_IDLE);
  assign bus_rd    = (st == S_RD)  || ((st == S_FLY) && !side);
  assign bus_wr    = (st == S_WR)  || ((st == S_FLY) &&  side);
  assign bus_addr  = bus_rd ? src[cur] : dst[cur];
  assign bus_wdata = hold;
  assign ack       = ((bus_rd && !side) || (bus_wr && side)) ? (NCH'(1) << cur) : '0;
  assign done      = done_r;
  assign irq       = |(done_r & ie_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (|pend) st <= S_REQ;
        S_REQ:  if (bus_gnt) st <= S_ARB;
        S_ARB:  begin
          if (|pend) begin
            cur <= win;
            st  <= ctl[win][B_IND] ? S_RD : S_FLY;
          end else begin
            st <= S_IDLE;
          end
        end
        S_FLY:  st <= S_CHK;
        S_RD:   begin
          hold <= bus_rdata;
          st   <= S_WR;
        end
        S_WR:   st <= S_CHK;
        S_CHK:  begin
          if (cc[B_CONT] && pend[cur]) st <= cc[B_IND] ? S_RD : S_FLY;
          else                         st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src[i] <= '0;
        dst[i] <= '0;
        cnt[i] <= '0;
        ctl[i] <= '0;
      end
      done_r <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (item_end && cur == CHW'(i)) begin
          src[i] <= stepped(src[i], ctl[i][B_SS +: 2]);
          dst[i] <= stepped(dst[i], ctl[i][B_DS +: 2]);
          cnt[i] <= cnt[i] - CW'(1);
          if (cnt[i] == CW'(1)) begin
            done_r[i]    <= 1'b1;
            ctl[i][B_EN] <= 1'b0;
            ctl[i][B_SW] <= 1'b0;
          end
        end
        if (cfg_we && cfg_ch == CHW'(i)) begin
          case (cfg_sel)
            2'd0: src[i] <= cfg_wdata;
            2'd1: dst[i] <= cfg_wdata;
            2'd2: cnt[i] <= CW'(cfg_wdata);
            default: begin
              ctl[i]    <= CB'(cfg_wdata);
              done_r[i] <= 1'b0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ack,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [NCH-1:0] done,
  input logic           irq
);
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ack_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> (bus_rd || bus_wr));

  assert_owned_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_req && bus_gnt));

  assert_no_cycle_at_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !(bus_rd || bus_wr));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|done));
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .done(done), .irq(irq)
);

// File: tb/sim_dma4_engine.sv
module sim_dma4_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  req_pri_tb = '0;
  logic [3:0]  req_sec = '0;
  logic [3:0]  req_pri;
  logic [3:0]  ack;
  logic        bus_req, bus_rd, bus_wr, irq;
  logic        bus_gnt = 1'b0;
  logic        gnt_block = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  done;

  int checks = 0, fails = 0, cyc = 0, nlog = 0, rises = 0, gnt_rise_cyc = 0;
  logic        prev_req = 1'b0, prev_gnt = 1'b0;
  logic        drop_mode = 1'b0;
  int          drop_base = 0;
  logic [15:0] la [0:511];
  logic [7:0]  lwd [0:511];
  logic [3:0]  lack [0:511];
  logic        lrd [0:511];
  logic        lwr [0:511];
  int          lcyc [0:511];

  always #10 clk = ~clk;

  assign bus_rdata = bus_addr[7:0] ^ 8'hA5;
  assign req_pri = req_pri_tb & ~((drop_mode && nlog > drop_base) ? 4'b0010 : 4'b0000);

  always @(posedge clk) bus_gnt <= bus_req & ~gnt_block;

  dma4_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_pri(req_pri), .req_sec(req_sec), .ack(ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done), .irq(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && !prev_req) rises <= rises + 1;
    if (bus_gnt && !prev_gnt) gnt_rise_cyc <= cyc;
    prev_req <= bus_req;
    prev_gnt <= bus_gnt;
    if ((bus_rd || bus_wr) && nlog < 512) begin
      la[nlog] <= bus_addr; lwd[nlog] <= bus_wdata; lack[nlog] <= ack;
      lrd[nlog] <= bus_rd; lwr[nlog] <= bus_wr; lcyc[nlog] <= cyc;
      nlog <= nlog + 1;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] mk(input bit en, ind, cont, ie, side,
                                     input int ss, ds, input bit sel, sw);
    mk = {5'd0, sw, sel, 2'(ds), 2'(ss), side, ie, cont, ind, en};
  endfunction

  function automatic int dlt(input int m);
    dlt = (m == 1) ? 1 : ((m == 2) ? -1 : 0);
  endfunction

  task automatic wait_done(input logic [3:0] m, input string tag);
    int n = 0;
    while ((done & m) != m && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 32'(done & m), 32'(m));
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    int b = nlog;
    repeat (20) @(negedge clk);
    chk(tag, {31'd0, bus_req}, 0);
    chk(tag, 32'(nlog - b), 0);
  endtask

  initial begin
    int b, r;
    logic [15:0] base, exp_a, db;
    repeat (3) @(negedge clk);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 strobes", {30'd0, bus_rd, bus_wr}, 0);
    chk("R1 ack/done/irq", {23'd0, ack, done, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {31'd0, bus_req}, 0);

    // R4 R7 R9 flyby read side, continuous, source stepping sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int sm = 0; sm < 4; sm++) begin
        base = 16'h1000 + 16'(ch * 256) + 16'(sm * 16);
        cfg(ch, 0, base); cfg(ch, 1, 16'h8000); cfg(ch, 2, 16'd3);
        b = nlog; r = rises;
        req_pri_tb[ch] = 1'b1;
        cfg(ch, 3, mk(1, 0, 1, ch[0], 0, sm, 1, 0, 0));
        wait_done(4'(1 << ch), "R8 flyby done");
        req_pri_tb[ch] = 1'b0;
        chk("R8 item count", 32'(nlog - b), 3);
        chk("R9 one ownership", 32'(rises - r), 1);
        chk("R8 irq", {31'd0, irq}, {31'd0, ch[0]});
        for (int k = 0; k < 3; k++) begin
          exp_a = 16'(int'(base) + k * dlt(sm));
          chk("R7 src step", {16'd0, la[b+k]}, {16'd0, exp_a});
          chk("R4 read strobe", {30'd0, lrd[b+k], lwr[b+k]}, 2);
          chk("R6 ack", {28'd0, lack[b+k]}, 32'(1 << ch));
        end
        cfg(ch, 3, 16'd0);
        chk("R8 done cleared", {28'd0, done}, 0);
      end
    end

    // R4 R7 R9 flyby write side, non-continuous, destination stepping sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int dm = 0; dm < 4; dm++) begin
        base = 16'h4000 + 16'(ch * 256) + 16'(dm * 16);
        cfg(ch, 0, 16'h0100); cfg(ch, 1, base); cfg(ch, 2, 16'd2);
        b = nlog; r = rises;
        req_sec[ch] = 1'b1;
        cfg(ch, 3, mk(1, 0, 0, 0, 1, 1, dm, 1, 0));
        wait_done(4'(1 << ch), "R8 flyby write done");
        req_sec[ch] = 1'b0;
        chk("R9 release per item", 32'(rises - r), 2);
        for (int k = 0; k < 2; k++) begin
          exp_a = 16'(int'(base) + k * dlt(dm));
          chk("R7 dst step", {16'd0, la[b+k]}, {16'd0, exp_a});
          chk("R4 write strobe", {30'd0, lrd[b+k], lwr[b+k]}, 1);
          chk("R6 ack write side", {28'd0, lack[b+k]}, 32'(1 << ch));
        end
        chk("R8 no irq when disabled", {31'd0, irq}, 0);
        cfg(ch, 3, 16'd0);
      end
    end

    // R5 R6 indirect, software request
    for (int ch = 0; ch < 4; ch++) begin
      for (int sd = 0; sd < 2; sd++) begin
        base = 16'h2000 + 16'(ch * 64);
        db   = 16'h6000 + 16'(ch * 64);
        cfg(ch, 0, base); cfg(ch, 1, db); cfg(ch, 2, 16'd2);
        b = nlog;
        cfg(ch, 3, mk(1, 1, 1, 1, sd[0], 1, 2, 0, 1));
        wait_done(4'(1 << ch), "R5 indirect done");
        chk("R5 cycles", 32'(nlog - b), 4);
        for (int k = 0; k < 2; k++) begin
          exp_a = base + 16'(k);
          chk("R5 read addr", {16'd0, la[b+2*k]}, {16'd0, exp_a});
          chk("R5 read strobe", {31'd0, lrd[b+2*k]}, 1);
          chk("R5 write addr", {16'd0, la[b+2*k+1]}, {16'd0, db - 16'(k)});
          chk("R5 write strobe", {31'd0, lwr[b+2*k+1]}, 1);
          chk("R5 write data", {24'd0, lwd[b+2*k+1]}, {24'd0, exp_a[7:0] ^ 8'hA5});
          chk("R5 back to back", 32'(lcyc[b+2*k+1] - lcyc[b+2*k]), 1);
          chk("R6 ack on read", {28'd0, lack[b+2*k]}, sd ? 0 : 32'(1 << ch));
          chk("R6 ack on write", {28'd0, lack[b+2*k+1]}, sd ? 32'(1 << ch) : 0);
        end
        chk("R8 irq enabled", {31'd0, irq}, 1);
        chk("R10 sw bit self-clears", {31'd0, bus_req}, 0);
        cfg(ch, 3, 16'd0);
        chk("R8 irq cleared", {31'd0, irq}, 0);
      end
    end

    // R2 priority and latency
    gnt_block = 1'b1;
    for (int ch = 3; ch >= 0; ch--) begin
      cfg(ch, 0, 16'h0300 + 16'(ch)); cfg(ch, 2, 16'd1);
      cfg(ch, 3, mk(1, 0, 0, 0, 0, 0, 0, 0, 1));
    end
    b = nlog;
    repeat (10) @(negedge clk);
    chk("R3 no cycle without grant", 32'(nlog - b), 0);
    chk("R3 request held", {31'd0, bus_req}, 1);
    gnt_block = 1'b0;
    repeat (2) @(negedge clk);
    r = gnt_rise_cyc;
    wait_done(4'hF, "R2 all served");
    chk("R2 latency from grant", 32'(lcyc[b] - r), 2);
    for (int k = 0; k < 4; k++)
      chk("R2 priority order", {28'd0, lack[b+k]}, 32'(1 << k));
    for (int ch = 0; ch < 4; ch++) cfg(ch, 3, 16'd0);

    // R9 continuous, request drops after first item
    cfg(1, 0, 16'h0500); cfg(1, 2, 16'd3);
    b = nlog;
    drop_base = nlog; drop_mode = 1'b1;
    req_pri_tb[1] = 1'b1;
    cfg(1, 3, mk(1, 0, 1, 0, 0, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk("R9 stop on low request", 32'(nlog - b), 1);
    chk("R9 bus released", {31'd0, bus_req}, 0);
    chk("R8 not yet done", {28'd0, done}, 0);
    drop_mode = 1'b0;
    wait_done(4'b0010, "R9 resume");
    chk("R9 total items", 32'(nlog - b), 3);
    chk("R7 address kept", {16'd0, la[b+2]}, 32'h0502);
    req_pri_tb[1] = 1'b0;
    cfg(1, 3, 16'd0);

    // R10 R11 request source selection, disable, zero count
    cfg(2, 0, 16'h0700); cfg(2, 2, 16'd1);
    cfg(2, 3, mk(1, 0, 0, 0, 0, 0, 0, 1, 0));
    req_pri_tb[2] = 1'b1;
    idle_check("R10 unselected line ignored");
    req_sec[2] = 1'b1;
    wait_done(4'b0100, "R10 secondary line served");
    req_sec[2] = 1'b0; req_pri_tb[2] = 1'b0;
    cfg(2, 3, 16'd0);
    cfg(3, 2, 16'd4);
    req_pri_tb[3] = 1'b1;
    cfg(3, 3, mk(0, 0, 1, 1, 0, 1, 1, 0, 1));
    idle_check("R11 disabled channel");
    cfg(0, 2, 16'd0);
    cfg(0, 3, mk(1, 0, 0, 0, 0, 0, 0, 0, 1));
    idle_check("R11 zero count");
    chk("R11 no done", {28'd0, done}, 0);
    req_pri_tb[3] = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule